// File: doc/BRIEF.md
# Double-Buffered Byte Write Serializer

This block turns a stream of host-supplied bytes into a continuous serial bit stream, for example the data path toward a magnetic write head. The host writes each byte into a holding register over a narrow parallel port. A shift engine runs without stopping. At every byte boundary it copies the holding register into its shift register and sends the byte out MSB first, one bit for each bit-cell enable pulse. The same edge that performs the copy also raises a sticky byte-ready flag. The host clears that flag with an acknowledge and may then put the following byte in the holding register. So the host is always writing byte N while byte N-1 is on the line.

The engine never inserts an idle gap. When the host has not written a new value by the next boundary, the old holding value is loaded again and repeated. The write-mode input gates everything. When it drops, serialization stops on the next clock and the byte in flight is cut short. The engine has two states. `ST_IDLE` holds the line low. `ST_SHIFT` is shifting. There are three transitions:
- *start*: `ST_IDLE` to `ST_SHIFT`, taken on a bit-cell enable in write mode, which performs the first load.
- *reload*: `ST_SHIFT` to `ST_SHIFT`, taken on the enable that completes 8 bits.
- *stop*: `ST_SHIFT` to `ST_IDLE`, taken whenever write mode is low.

Top module: `wr_serializer`

## Requirements
- R1: A synchronous reset clears the holding register, the shift register, the bit counter and byte_rdy, and drives ser_out low.
- R2: A clock edge with host_we high stores host_wdata into the holding register.
- R3: In ST_IDLE with wr_mode high, the first bit_en loads the holding register. After that edge ser_out shows bit 7 of the loaded byte and byte_rdy is 1.
- R4: Bits leave MSB first. Each bit_en in ST_SHIFT advances one bit, and ser_out is unchanged on cycles without bit_en.
- R5: A byte lasts exactly 8 bit_en pulses. The 8th pulse reloads from the holding register on the same edge with no gap, and that same edge sets byte_rdy.
- R6: If the host wrote nothing since the last load, the next boundary loads and repeats the same byte.
- R7: A host write while a byte is shifting does not disturb that byte. A write on the same edge as a load goes to the next byte, and the load takes the previous holding value.
- R8: byte_rdy stays set until rdy_ack is high at an edge. When rdy_ack and a load happen on the same edge, byte_rdy ends set.
- R9: An edge with wr_mode low moves the engine to ST_IDLE. ser_out is low after that edge, and the unfinished byte is lost. Re-entering write mode restarts at R3.
- R10: While wr_mode is low, bit_en has no effect: ser_out stays low and byte_rdy is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_mode | input | 1 | 1 = write (serialize), 0 = read (stopped) |
| bit_en | input | 1 | Bit-cell enable, one pulse per output bit |
| host_we | input | 1 | Host write strobe for the holding register |
| host_wdata | input | DATA_W | Host byte |
| rdy_ack | input | 1 | Host acknowledge, clears byte_rdy |
| byte_rdy | output | 1 | Sticky flag, set at each load |
| ser_out | output | 1 | Serial data stream |

## Verification
Several rules are checked on every cycle by the assertions:
- a load always captures the holding value of the previous cycle;
- a shift moves the register by exactly one place;
- the register is frozen between enables;
- a load leaves byte_rdy set;
- a host write lands in the holding register;
- a cycle with write mode low always leaves the line low.

Other behaviour only the bench's scenarios can show:
- that 8 enables make a byte;
- that an unserviced boundary repeats the old byte;
- that a dropped write mode truncates a byte partway through;
- that enables outside write mode change nothing;
- that the host/line pipelining of one byte holds over a real sequence of bytes.

// File: rtl/wser_pkg.sv
package wser_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } wser_state_e;
endpackage

// File: rtl/wser_hold_reg.sv
module wser_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] hold
);
    always_ff @(posedge clk) begin
        if (rst)     hold <= '0;
        else if (we) hold <= wdata;
    end

    // R2: a host write lands in the holding register
    p_host_write_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> hold == $past(wdata));
endmodule

// File: rtl/wser_rdy_flag.sv
module wser_rdy_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;   // set wins over clear
        else if (clr) flag <= 1'b0;
    end

    // R8: a load always leaves the flag set, even with acknowledge
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    // R8: without a load, the flag can only rise through set
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag && !set) |=> !flag);
endmodule

// File: rtl/wser_shift_fsm.sv
module wser_shift_fsm
    import wser_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              bit_en,
    input  logic [DATA_W-1:0] hold,
    output logic              load,
    output logic              ser_out
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    wser_state_e       state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              step;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next state: start, reload (self loop), stop
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (wr_mode && bit_en) state_nx = ST_SHIFT;
            ST_SHIFT: if (!wr_mode)          state_nx = ST_IDLE;
            default:                         state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        step    = 1'b0;
        ser_out = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = wr_mode && bit_en;
            end
            ST_SHIFT: begin
                ser_out = shreg[DATA_W-1];
                load    = wr_mode && bit_en && (cnt == LAST);
                step    = wr_mode && bit_en && (cnt != LAST);
            end
            default: ;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load) begin
            shreg <= hold;
            cnt   <= '0;
        end else if (step) begin
            shreg <= {shreg[DATA_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
        end
    end

    // R7: a load captures the holding value seen before the edge
    p_load_old_hold_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> shreg == $past(hold));
    // R4: one enable moves the register by one place
    p_shift_one_r4: assert property (@(posedge clk) disable iff (rst)
        step |=> shreg == {$past(shreg[DATA_W-2:0]), 1'b0});
    // R4: no enable, no change on the line
    p_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (!bit_en && wr_mode) |=> $stable(shreg));
    // R9: write mode low silences the line on the next cycle
    p_exit_low_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_mode |=> !ser_out);
endmodule

// File: rtl/wr_serializer.sv
module wr_serializer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              bit_en,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              rdy_ack,
    output logic              byte_rdy,
    output logic              ser_out
);
    logic [DATA_W-1:0] hold;
    logic              load;

    wser_hold_reg #(.DATA_W(DATA_W)) hold_i (
        .clk(clk), .rst(rst), .we(host_we), .wdata(host_wdata), .hold(hold)
    );

    wser_shift_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .bit_en(bit_en),
        .hold(hold), .load(load), .ser_out(ser_out)
    );

    wser_rdy_flag rdy_i (
        .clk(clk), .rst(rst), .set(load), .clr(rdy_ack), .flag(byte_rdy)
    );

    // R10: outside write mode the flag never rises
    p_no_set_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_mode && !byte_rdy) |=> !byte_rdy);
endmodule

// File: tb/wr_serializer_tb.sv
`timescale 1ns/1ps
module wr_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_mode = 1'b0, bit_en = 1'b0, host_we = 1'b0, rdy_ack = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       byte_rdy, ser_out;

    always #4 clk = ~clk;   // 125 MHz

    wr_serializer #(.DATA_W(8)) dut_i (
        .clk(clk), .rst(rst), .wr_mode(wr_mode), .bit_en(bit_en),
        .host_we(host_we), .host_wdata(host_wdata), .rdy_ack(rdy_ack),
        .byte_rdy(byte_rdy), .ser_out(ser_out)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [7:0] m_hold = '0, m_byte = '0;
    int         m_idx = 0;
    bit         m_act = 0, m_rdy = 0, m_ld;
    int         m_loads = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_hold = '0; m_byte = '0; m_idx = 0; m_act = 0; m_rdy = 0;
        end else begin
            m_ld = 0;
            if (!wr_mode) m_act = 0;
            else if (bit_en) begin
                if (!m_act || m_idx == 7) begin
                    m_byte = m_hold; m_idx = 0; m_act = 1; m_ld = 1; m_loads++;
                end else m_idx++;
            end
            if (m_ld) m_rdy = 1;
            else if (rdy_ack) m_rdy = 0;
            if (host_we) m_hold = host_wdata;
        end
    end

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        check(cur_req, "ser_out", ser_out, m_act ? m_byte[7 - m_idx] : 1'b0);
        check(cur_req, "byte_rdy", byte_rdy, m_rdy);
    end

    // bit-cell enable generator
    int en_period = 0, en_cnt = 0;
    always @(negedge clk) begin
        if (en_period == 0) bit_en <= 1'b0;
        else begin
            bit_en <= (en_cnt == 0);
            en_cnt <= (en_cnt + 1 >= en_period) ? 0 : en_cnt + 1;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host_byte(logic [7:0] d);
        host_we = 1'b1; rdy_ack = 1'b1; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; rdy_ack = 1'b0;
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int loads0;
        cur_req = "R1";
        wait_cyc(3);
        check("R1", "reset ser_out", ser_out, 1'b0);
        check("R1", "reset byte_rdy", byte_rdy, 1'b0);
        rst = 1'b0;

        // R2 / R10: write in read mode, enables do nothing
        cur_req = "R10";
        host_wdata = 8'hA5; host_we = 1'b1; @(negedge clk); host_we = 1'b0;
        en_period = 2; wait_cyc(20);
        check("R10", "no flag in read mode", byte_rdy, 1'b0);

        // R3/R4/R5: start, host services each byte
        cur_req = "R3";
        en_period = 3; wr_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            while (!byte_rdy) @(negedge clk);
            if (k == 0) check("R3", "first load flag", byte_rdy, 1'b1);
            cur_req = (k < 3) ? "R5" : "R4";
            host_byte(8'h3C + 8'(k * 37));
        end

        // R6: no more host writes, bytes repeat
        cur_req = "R6";
        loads0 = m_loads;
        rdy_ack = 1'b1; wait_cyc(3 * 8 * 3); rdy_ack = 1'b0;
        check("R6", "repeat loads happened", 1'(m_loads - loads0 >= 2), 1'b1);

        // R7/R8: enable every cycle, write and ack every cycle
        cur_req = "R7";
        en_period = 1;
        for (int k = 0; k < 40; k++) begin
            host_we = 1'b1; host_wdata = 8'(k * 29 + 5); rdy_ack = 1'b1;
            @(negedge clk);
        end
        host_we = 1'b0;
        cur_req = "R8";
        wait_cyc(30);
        rdy_ack = 1'b0;
        wait_cyc(12);
        check("R8", "sticky flag", byte_rdy, 1'b1);

        // R9: drop write mode mid byte, then re-enter
        cur_req = "R9";
        en_period = 2; host_byte(8'hF0); wait_cyc(7);
        wr_mode = 1'b0; @(negedge clk); @(negedge clk);
        check("R9", "line low after stop", ser_out, 1'b0);
        wait_cyc(10);
        host_byte(8'h81);
        cur_req = "R10"; wait_cyc(6);
        cur_req = "R9"; wr_mode = 1'b1; wait_cyc(50);

        en_period = 0; wait_cyc(4);
        summary();
    end
endmodule